// File: doc/BRIEF.md
# Half-Bridge Gate Controller with Short-Circuit Retry

This block is the digital control core of one half-bridge leg. It receives an upper and a lower switch command, a disable/reset level, a sleep request, an active-low auto-retry enable and one desaturation detect per transistor. It drives the two gate enables and an active-low short-circuit flag. The command pair selects whether the leg output is pulled to the positive rail, pulled to the negative rail or left floating. The block enforces a dead band between the two gates and treats both commands high at once as a fault.

A short on the conducting transistor, or an illegal command pair, latches the fault. The gates then turn off and the flag goes low. The fault clears in one of two ways. With auto-retry inactive, a low pulse on disable/reset of a minimum width that follows a high level clears it. With auto-retry active, a timed window clears it, and the trip and retry repeat for as long as the short persists. All timing parameters are in nanoseconds or microseconds and are converted to cycle counts from a clock-frequency parameter. Every asynchronous input passes through a two-flop synchronizer.

Top module: `hb_gate_ctrl`

## Requirements
- R1: With the drive enabled, upper=1/lower=0 turns on only the high gate, upper=0/lower=1 turns on only the low gate, and 0/0 leaves both gates off.
- R2: When upper and lower are both 1 while the drive is enabled, the fault latches (flag low). The two gates are never on in the same cycle.
- R3: A gate turns on only after the opposite gate has been off for at least DEAD_NS worth of cycles.
- R4: When disable/reset is 1, both gates are off.
- R5: With auto-retry inactive (auto_n=1), the fault clears only after disable/reset has been 1 and then 0 for at least RSTPW_NS worth of cycles. A shorter low pulse leaves the fault set.
- R6: A desaturation detect on the transistor whose gate is on latches the fault and turns that gate off on the next cycle. A detect on the transistor that is off has no effect.
- R7: Desaturation detects are ignored for BLANK_NS worth of cycles after each gate turns on.
- R8: With auto-retry active (auto_n=0), a latched fault clears by itself after RETRY_US worth of cycles, and drive resumes.
- R9: If the short is still present after an automatic clear, the fault latches again, and the cycle repeats.
- R10: When sleep is 1, both gates are off.
- R11: With auto-retry active, a low pulse on disable/reset does not clear the fault.
- R12: After reset, both gates are off and the fault flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_cmd | input | 1 | Upper switch command |
| lo_cmd | input | 1 | Lower switch command |
| dis_rst | input | 1 | 1 = gates off; a low pulse after a high level clears the fault |
| sleep_req | input | 1 | 1 = drive disabled, output floating |
| auto_n | input | 1 | 0 = automatic timed fault retry active |
| desat_hi | input | 1 | Desaturation detect, high-side transistor |
| desat_lo | input | 1 | Desaturation detect, low-side transistor |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| sc_flt_n | output | 1 | Short-circuit fault flag, 0 = fault latched |

## Verification
The hardest state to reach is a short that persists through an automatic retry. To reach it, the stimulus holds the high-side detect asserted with the upper command applied and auto-retry active. It measures how long the flag stays low against the retry window, and then waits for the re-trip that follows the clear. While the fault is latched, the stimulus also issues a valid-width disable/reset pulse, which must be ignored. The blanking window is measured in the same way: the detect is raised before the gate turns on, so the gate's on-time equals the blanking length plus the trip latency.

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl #(
  parameter int CLK_MHZ  = 50,
  parameter int DEAD_NS  = 600,
  parameter int RSTPW_NS = 100,
  parameter int BLANK_NS = 1000,
  parameter int RETRY_US = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_cmd,
  input  logic lo_cmd,
  input  logic dis_rst,
  input  logic sleep_req,
  input  logic auto_n,
  input  logic desat_hi,
  input  logic desat_lo,
  output logic gate_hi,
  output logic gate_lo,
  output logic sc_flt_n
);
  localparam int DEAD_CYC  = (CLK_MHZ * DEAD_NS + 999) / 1000;
  localparam int RST_CYC   = ((CLK_MHZ * RSTPW_NS + 999) / 1000 < 1) ? 1 : (CLK_MHZ * RSTPW_NS + 999) / 1000;
  localparam int BLANK_CYC = (CLK_MHZ * BLANK_NS + 999) / 1000;
  localparam int RETRY_CYC = (CLK_MHZ * RETRY_US < 2) ? 2 : CLK_MHZ * RETRY_US;
  localparam int DW = $clog2(DEAD_CYC + 1) + 1;
  localparam int LW = $clog2(RST_CYC + 1) + 1;
  localparam int BW = $clog2(BLANK_CYC + 1) + 1;
  localparam int RW = $clog2(RETRY_CYC + 1) + 1;
  localparam logic [DW-1:0] DEAD_V  = DW'(DEAD_CYC);
  localparam logic [LW-1:0] RST_V   = LW'(RST_CYC - 1);
  localparam logic [BW-1:0] BLANK_V = BW'(BLANK_CYC);
  localparam logic [RW-1:0] RETRY_V = RW'(RETRY_CYC - 1);

  logic [6:0] s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {desat_lo, desat_hi, auto_n, sleep_req, dis_rst, lo_cmd, up_cmd};
      s2 <= s1;
    end

  logic s_up, s_lo, s_dis, s_slp, s_auto, s_dh, s_dl;
  assign {s_dl, s_dh, s_auto, s_slp, s_dis, s_lo, s_up} = s2;

  logic flt, armed;
  logic [DW-1:0] off_hi, off_lo;
  logic [BW-1:0] blk_hi, blk_lo;
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rty_cnt;

  wire enable  = !flt && !s_dis && !s_slp;
  wire want_hi = enable && s_up && !s_lo;
  wire want_lo = enable && s_lo && !s_up;
  wire trip    = (enable && s_up && s_lo)
              || (gate_hi && s_dh && blk_hi == BLANK_V)
              || (gate_lo && s_dl && blk_lo == BLANK_V);
  wire auto_clr = flt && !s_auto && rty_cnt == RETRY_V;
  wire man_clr  = flt && s_auto && armed && !s_dis && low_cnt == RST_V;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      off_hi  <= DEAD_V;
      off_lo  <= DEAD_V;
      blk_hi  <= '0;
      blk_lo  <= '0;
    end else begin
      gate_hi <= want_hi && !gate_lo && off_lo == DEAD_V;
      gate_lo <= want_lo && !gate_hi && off_hi == DEAD_V;
      off_hi  <= gate_hi ? '0 : (off_hi == DEAD_V ? off_hi : off_hi + 1'b1);
      off_lo  <= gate_lo ? '0 : (off_lo == DEAD_V ? off_lo : off_lo + 1'b1);
      blk_hi  <= !gate_hi ? '0 : (blk_hi == BLANK_V ? blk_hi : blk_hi + 1'b1);
      blk_lo  <= !gate_lo ? '0 : (blk_lo == BLANK_V ? blk_lo : blk_lo + 1'b1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt     <= 1'b0;
      armed   <= 1'b0;
      low_cnt <= '0;
      rty_cnt <= '0;
    end else begin
      if (!flt) flt <= trip;
      else if (auto_clr || man_clr) flt <= 1'b0;
      armed   <= flt && (armed || s_dis) && !man_clr;
      low_cnt <= s_dis ? '0 : (low_cnt == RST_V ? low_cnt : low_cnt + 1'b1);
      rty_cnt <= (!flt || s_auto || auto_clr) ? '0 : rty_cnt + 1'b1;
    end

  assign sc_flt_n = !flt;

  // R2
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(gate_hi && gate_lo));
  // R3
  dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_hi) |-> !$past(gate_lo));
  // R3
  dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(gate_lo) |-> !$past(gate_hi));
  // R6
  flt_gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n) !sc_flt_n |=> !gate_hi && !gate_lo);
  // R4
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n) s_dis |=> !gate_hi && !gate_lo);
  // R10
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n) s_slp |=> !gate_hi && !gate_lo);
endmodule

// File: tb/sim_hb_gate_ctrl.sv
module sim_hb_gate_ctrl;
  localparam int DEAD = 6, BLANK = 5, RETRY = 200;
  logic clk = 0, rst_n = 0;
  logic up_cmd = 0, lo_cmd = 0, dis_rst = 0, sleep_req = 0, auto_n = 1, desat_hi = 0, desat_lo = 0;
  logic gate_hi, gate_lo, sc_flt_n;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.CLK_MHZ(50), .DEAD_NS(120), .RSTPW_NS(100), .BLANK_NS(100), .RETRY_US(4)) u0 (
    .clk(clk), .rst_n(rst_n), .up_cmd(up_cmd), .lo_cmd(lo_cmd), .dis_rst(dis_rst),
    .sleep_req(sleep_req), .auto_n(auto_n), .desat_hi(desat_hi), .desat_lo(desat_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .sc_flt_n(sc_flt_n));

  // bits: up lo dis sleep exp_hi exp_lo
  localparam logic [5:0] VEC [10] = '{6'b000000, 6'b100010, 6'b000000, 6'b010001, 6'b100010,
                                      6'b101000, 6'b100010, 6'b010100, 6'b010001, 6'b000000};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cmd(input logic u, input logic l);
    up_cmd = u; lo_cmd = l;
  endtask

  task automatic clr_pulse();
    dis_rst = 1; cyc(4); dis_rst = 0; cyc(12);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    cyc(1);
    // R12 reset state
    chk(gate_hi == 0 && gate_lo == 0, "R12 gates", {gate_hi, gate_lo}, 0);
    chk(sc_flt_n == 1, "R12 flag", sc_flt_n, 1);
    rst_n = 1; cyc(3);

    foreach (VEC[i]) begin
      string req;
      up_cmd = VEC[i][5]; lo_cmd = VEC[i][4]; dis_rst = VEC[i][3]; sleep_req = VEC[i][2];
      req = VEC[i][3] ? "R4" : (VEC[i][2] ? "R10" : "R1");
      cyc(20);
      chk({gate_hi, gate_lo} == VEC[i][1:0], req, {gate_hi, gate_lo}, VEC[i][1:0]);
      chk(sc_flt_n == 1, req, sc_flt_n, 1);
    end

    // R3 dead band lo -> hi
    set_cmd(0, 1); cyc(20);
    set_cmd(1, 0);
    n = 0; while (gate_lo && n < 50) begin cyc(1); n++; end
    n = 0; while (!gate_hi && n < 50) begin cyc(1); n++; end
    chk(n >= DEAD && n <= DEAD + 3, "R3 gap hi", n, DEAD + 1);
    // R3 dead band hi -> lo
    set_cmd(0, 1);
    n = 0; while (gate_hi && n < 50) begin cyc(1); n++; end
    n = 0; while (!gate_lo && n < 50) begin cyc(1); n++; end
    chk(n >= DEAD && n <= DEAD + 3, "R3 gap lo", n, DEAD + 1);

    // R6 detect on the off transistor is ignored
    set_cmd(1, 0); cyc(20);
    desat_lo = 1; cyc(20);
    chk(sc_flt_n == 1 && gate_hi == 1, "R6 off-side ignored", {sc_flt_n, gate_hi}, 3);
    desat_lo = 0; set_cmd(0, 0); cyc(20);

    // R7 blanking: detect already high at turn-on
    desat_hi = 1; cyc(5);
    set_cmd(1, 0);
    n = 0; while (!gate_hi && n < 50) begin cyc(1); n++; end
    n = 0; while (gate_hi && n < 50) begin cyc(1); n++; end
    chk(n >= BLANK && n <= BLANK + 3, "R7 on-time", n, BLANK + 2);
    cyc(1);
    chk(sc_flt_n == 0, "R6 trip", sc_flt_n, 0);
    desat_hi = 0; set_cmd(0, 0); cyc(5);
    clr_pulse();
    chk(sc_flt_n == 1, "R5 clear", sc_flt_n, 1);

    // R2 illegal command
    set_cmd(1, 1); cyc(10);
    chk(sc_flt_n == 0 && gate_hi == 0 && gate_lo == 0, "R2 illegal", {sc_flt_n, gate_hi, gate_lo}, 0);
    set_cmd(0, 0); cyc(5);
    // R5 short pulse does not clear
    dis_rst = 1; cyc(4); dis_rst = 0; cyc(2); dis_rst = 1; cyc(6);
    chk(sc_flt_n == 0, "R5 short pulse", sc_flt_n, 0);
    dis_rst = 0; cyc(12);
    chk(sc_flt_n == 1, "R5 full pulse", sc_flt_n, 1);
    set_cmd(1, 0); cyc(20);
    chk(gate_hi == 1, "R5 drive resumes", gate_hi, 1);

    // R8 / R9 / R11 auto retry with persistent short
    auto_n = 0; cyc(4);
    desat_hi = 1;
    n = 0; while (sc_flt_n && n < 50) begin cyc(1); n++; end
    n = 0; while (!sc_flt_n && n < 400) begin cyc(1); n++; end
    chk(n >= RETRY - 1 && n <= RETRY + 1, "R8 retry window", n, RETRY);
    n = 0; while (sc_flt_n && n < 50) begin cyc(1); n++; end
    chk(sc_flt_n == 0 && n < 40, "R9 re-trip", n, BLANK + 5);
    clr_pulse();
    chk(sc_flt_n == 0, "R11 manual ignored", sc_flt_n, 0);
    desat_hi = 0;
    n = 0; while (!sc_flt_n && n < 400) begin cyc(1); n++; end
    cyc(30);
    chk(sc_flt_n == 1 && gate_hi == 1, "R8 recovered", {sc_flt_n, gate_hi}, 3);

    finish_run();
  end
endmodule